// File: doc/BRIEF.md
# Serial Host Port with Word Request Handshake

This block links an internal host to an external SPI bus. It holds a single word buffer in each direction. A mode input selects the role. As a slave, the block shifts words in on an SCK supplied from outside while the active-low select is low. It drives MISO only while it is selected. As a master, it makes SCK itself from the system clock with a programmable divider. Words are `WORD_W` bits wide (default 8), move MSB first, and use SPI mode 0: data changes after the falling SCK edge and is sampled on the rising edge.

A request line paces each word. In slave mode the block drives the line low while it can take a new word, and releases it on the first SCK pulse of that word. In master mode the line is an input: an external device pulls it low to start a word, and after each word the master waits for the line to go high and then low again. A request enable input can switch the handshake off. The line is then left undriven and the master starts as soon as a word is loaded. Two sticky flags report errors, and each has its own write-one-to-clear input: a bus error (select driven low while the block is master) and a receive overrun.

The control core is one state machine:
- `ST_IDLE` is the reset state. It moves to `ST_SREADY` or `ST_MWAIT` according to the mode.
- Slave path: `ST_SREADY` (request asserted) moves to `ST_SXFER` on the first selected rising SCK edge. `ST_SXFER` moves to `ST_SDONE` on the last rising edge, and back to `ST_SREADY` if select rises in mid-word (the word is aborted). `ST_SDONE` latches the received word and returns to `ST_SREADY`.
- Master path: `ST_MWAIT` moves to `ST_MXFER` when a word is loaded and the request permits. `ST_MXFER` moves to `ST_MDONE` on the falling edge after the last rising edge. `ST_MDONE` latches the received word and returns to `ST_MWAIT`.
- A change of mode moves any slave state to `ST_MWAIT` and any master state to `ST_SREADY`.

Top module: `hsp_port`

## Requirements
- R1: While reset is asserted, `hreq_o` is 1, `miso_oe` is 0, `sck_o` is 0, and `rx_valid`, `tx_full`, `bus_err` and `overrun` are all 0.
- R2: In slave mode with `ss_n_i` high, SCK edges have no effect: no word is received, `rx_valid` stays 0 and `miso_oe` stays 0.
- R3: In slave mode with `ss_n_i` low, MOSI is sampled on each rising SCK edge. After `WORD_W` edges the word, first bit in the MSB, appears on `rx_data` and `rx_valid` becomes 1.
- R4: In slave mode with `ss_n_i` low, `miso_oe` is 1 and `miso_o` presents the loaded transmit word MSB first, one bit per rising edge. `tx_full` is set by `tx_load` and clears once the word starts.
- R5: In slave mode with the handshake enabled, `hreq_o` is 0 while the port is ready for a word. It goes to 1 after the first rising SCK edge of a word and returns to 0 once the word completes.
- R6: With `hreq_en` at 0, `hreq_oe` is 0 in both modes and the master starts a loaded word without regard to `hreq_i`. With `hreq_en` at 1 in slave mode, `hreq_oe` is 1.
- R7: In master mode the port starts a word only when `tx_full` is 1 and `hreq_i` is low. It then gives exactly `WORD_W` SCK pulses, drives the word on `mosi_o` MSB first, and captures MISO into `rx_data`.
- R8: After a master word, a `hreq_i` held continuously low does not start another word. The line must first go high and then low again.
- R9: `bus_err` is set when `ss_n_i` is low in master mode. It stays set until `clr_flags[0]` is pulsed.
- R10: If a word completes while `rx_valid` is still 1 and `rx_read` is not pulsed, `overrun` is set and `rx_data` takes the new word. `clr_flags[1]` clears `overrun`, and `rx_read` clears `rx_valid`.
- R11: In master mode each SCK half period lasts `clk_div+1` system clock cycles.
- R12: In master mode SCK is low between words. `sck_oe` and `mosi_oe` are 1 exactly when `mode_master` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 selects master role, 0 selects slave role |
| hreq_en | input | 1 | Enables the request handshake |
| clk_div | input | DIV_W | Master SCK half period minus one, in clock cycles |
| sck_i | input | 1 | SCK from the external master (slave mode) |
| ss_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data in, slave mode |
| miso_i | input | 1 | Serial data in, master mode |
| hreq_i | input | 1 | Request from the external slave, active low |
| sck_o | output | 1 | Generated SCK |
| sck_oe | output | 1 | Drive enable for SCK |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Drive enable for MOSI |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Drive enable for MISO |
| hreq_o | output | 1 | Ready request, active low, slave mode |
| hreq_oe | output | 1 | Drive enable for the request line |
| tx_data | input | WORD_W | Word to transmit |
| tx_load | input | 1 | Writes `tx_data` into the transmit buffer |
| tx_full | output | 1 | Transmit buffer holds an unsent word |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | `rx_data` not yet read |
| rx_read | input | 1 | Acknowledges `rx_data` |
| clr_flags | input | 2 | Write-one-to-clear: bit 0 bus error, bit 1 overrun |
| bus_err | output | 1 | Sticky bus-error flag |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The assertions assume that the external SCK, select and request inputs stay stable for several system clocks around each change, so that the two-stage synchronizers see every level. They also assume that the mode input changes only while select is high and no word is in flight. The stimulus keeps to these assumptions:
- Every SCK half period lasts six clocks.
- The request line is held for at least four clocks.
- The mode is switched only after select has been high for several cycles.
- In master mode, select stays high except in the one phase that provokes the bus error.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SREADY,
        ST_SXFER,
        ST_SDONE,
        ST_MWAIT,
        ST_MXFER,
        ST_MDONE
    } hsp_state_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsp_clkgen.sv
module hsp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise_tk,
    output logic             fall_tk
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick    = run && (cnt == div);
    assign rise_tk = tick && !sck;
    assign fall_tk = tick && sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (sck != $past(sck))) |-> ($past(cnt) == $past(div))); // R11
endmodule

// File: rtl/hsp_shreg.sv
module hsp_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tx_shift,
    input  logic         rx_shift,
    input  logic         rx_bit,
    output logic         tx_msb,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_word <= '0;
        end else begin
            if (load)          tx_q <= load_val;
            else if (tx_shift) tx_q <= {tx_q[W-2:0], 1'b0};
            if (rx_shift)      rx_word <= {rx_word[W-2:0], rx_bit};
        end
    end

    assign tx_msb = tx_q[W-1];
endmodule

// File: rtl/hsp_port.sv
module hsp_port
    import hsp_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              hreq_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    input  logic              hreq_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              hreq_o,
    output logic              hreq_oe,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_load,
    output logic              tx_full,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_read,
    input  logic [1:0]        clr_flags,
    output logic              bus_err,
    output logic              overrun
);
    localparam int BCNT_W = $clog2(WORD_W + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);
    localparam logic [BCNT_W-1:0] ALL_BITS = BCNT_W'(WORD_W);

    hsp_state_e        state, nxt;
    logic [3:0]        sync_q;
    logic              sck_s, ss_s, mosi_s, hreq_s, sck_d;
    logic              sl_rise, sl_fall;
    logic              rise_tk, fall_tk, gen_sck, run;
    logic [BCNT_W-1:0] bitcnt;
    logic [WORD_W-1:0] tx_buf, rx_word;
    logic              armed, start, word_start, done;
    logic              sh_load, tx_shift, rx_shift, rx_bit, tx_msb;

    hsp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, ss_n_i, mosi_i, hreq_i}),
        .q     (sync_q)
    );
    assign {sck_s, ss_s, mosi_s, hreq_s} = sync_q;

    assign sl_rise = sck_s && !sck_d && !ss_s;
    assign sl_fall = !sck_s && sck_d && !ss_s;

    assign run = (state == ST_MXFER);
    hsp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div     (clk_div),
        .sck     (gen_sck),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    assign start      = tx_full && (!hreq_en || (!hreq_s && armed));
    assign word_start = ((state == ST_SREADY) && (nxt == ST_SXFER)) ||
                        ((state == ST_MWAIT) && (nxt == ST_MXFER));
    assign done       = (state == ST_SDONE) || (state == ST_MDONE);

    assign sh_load  = (state == ST_SREADY) || (state == ST_MWAIT);
    assign tx_shift = ((state == ST_SXFER) && sl_fall) ||
                      ((state == ST_MXFER) && fall_tk && (bitcnt != ALL_BITS));
    assign rx_shift = ((state == ST_SREADY || state == ST_SXFER) && sl_rise && !mode_master) ||
                      ((state == ST_MXFER) && rise_tk);
    assign rx_bit   = (state == ST_MXFER) ? miso_i : mosi_s;

    hsp_shreg #(.W(WORD_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (tx_buf),
        .tx_shift (tx_shift),
        .rx_shift (rx_shift),
        .rx_bit   (rx_bit),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = mode_master ? ST_MWAIT : ST_SREADY;
            ST_SREADY: begin
                if (mode_master)  nxt = ST_MWAIT;
                else if (sl_rise) nxt = ST_SXFER;
            end
            ST_SXFER: begin
                if (mode_master)                        nxt = ST_MWAIT;
                else if (ss_s)                          nxt = ST_SREADY;
                else if (sl_rise && bitcnt == LAST_BIT) nxt = ST_SDONE;
            end
            ST_SDONE:  nxt = mode_master ? ST_MWAIT : ST_SREADY;
            ST_MWAIT: begin
                if (!mode_master) nxt = ST_SREADY;
                else if (start)   nxt = ST_MXFER;
            end
            ST_MXFER: begin
                if (!mode_master)                        nxt = ST_SREADY;
                else if (fall_tk && bitcnt == ALL_BITS)  nxt = ST_MDONE;
            end
            ST_MDONE:  nxt = mode_master ? ST_MWAIT : ST_SREADY;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            bitcnt   <= '0;
            tx_buf   <= '0;
            tx_full  <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            overrun  <= 1'b0;
            bus_err  <= 1'b0;
            armed    <= 1'b1;
        end else begin
            sck_d <= sck_s;

            if (tx_load) begin
                tx_buf  <= tx_data;
                tx_full <= 1'b1;
            end else if (word_start) begin
                tx_full <= 1'b0;
            end

            if (rx_shift)
                bitcnt <= bitcnt + 1'b1;
            else if (nxt != ST_SXFER && nxt != ST_MXFER)
                bitcnt <= '0;

            if (done) begin
                rx_data  <= rx_word;
                rx_valid <= 1'b1;
            end else if (rx_read) begin
                rx_valid <= 1'b0;
            end

            if (done && rx_valid && !rx_read) overrun <= 1'b1;
            else if (clr_flags[1])            overrun <= 1'b0;

            if (mode_master && !ss_s) bus_err <= 1'b1;
            else if (clr_flags[0])    bus_err <= 1'b0;

            if ((state == ST_MWAIT) && (nxt == ST_MXFER)) armed <= 1'b0;
            else if (hreq_s)                              armed <= 1'b1;
        end
    end

    // Pin outputs
    always_comb begin
        sck_o   = gen_sck;
        sck_oe  = mode_master;
        mosi_o  = tx_msb;
        mosi_oe = mode_master;
        miso_o  = tx_msb;
        miso_oe = !mode_master && !ss_s &&
                  (state == ST_SREADY || state == ST_SXFER || state == ST_SDONE);
        hreq_o  = (state != ST_SREADY);
        hreq_oe = hreq_en && !mode_master && (state != ST_IDLE);
    end

    AST_BUSERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !clr_flags[0]) |=> bus_err); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_flags[1]) |=> overrun); // R10
    AST_HREQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SREADY) && !mode_master && sl_rise) |=> hreq_o); // R5
    AST_RX_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> ($past(state) == ST_SDONE || $past(state) == ST_MDONE)); // R3
    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MXFER) && ($past(state) == ST_MWAIT) && $past(hreq_en)) |-> !$past(hreq_s)); // R7
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_MXFER) && ($past(state) != ST_MXFER)) |-> !sck_o); // R12
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bitcnt <= ALL_BITS)); // R7
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_master = 1'b0, hreq_en = 1'b1;
    logic [7:0] clk_div = 8'd2;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, hreq_i = 1'b1;
    logic       miso_i;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, hreq_o, hreq_oe;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0, tx_full;
    logic [7:0] rx_data;
    logic       rx_valid, rx_read = 1'b0;
    logic [1:0] clr_flags = 2'b00;
    logic       bus_err, overrun;

    int vecs = 0, errs = 0, settle = 0, rise_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] sl_sh = 8'h00, mosi_cap = 8'h00;
    time t_prev = 0, t_last = 0;
    byte unsigned exp_rx [$];

    always #10 clk = ~clk;

    hsp_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .hreq_en(hreq_en),
        .clk_div(clk_div), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
        .miso_i(miso_i), .hreq_i(hreq_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_o(miso_o), .miso_oe(miso_oe),
        .hreq_o(hreq_o), .hreq_oe(hreq_oe), .tx_data(tx_data), .tx_load(tx_load),
        .tx_full(tx_full), .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
        .clr_flags(clr_flags), .bus_err(bus_err), .overrun(overrun)
    );

    // Behavioural external slave for master mode
    assign miso_i = sl_sh[7];
    always @(negedge sck_o) sl_sh <= {sl_sh[6:0], 1'b0};
    always @(posedge sck_o) begin
        mosi_cap <= {mosi_cap[6:0], mosi_o};
        rise_cnt <= rise_cnt + 1;
        t_prev   <= t_last;
        t_last   <= $time;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_tx(input logic [7:0] w);
        tx_data = w; tx_load = 1'b1; cyc(1); tx_load = 1'b0;
    endtask

    task automatic read_rx();
        rx_read = 1'b1; cyc(1); rx_read = 1'b0;
    endtask

    task automatic slave_word(input logic [7:0] w, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = w[i];
            cyc(H);
            got[i] = miso_o;
            sck_i = 1'b1;
            cyc(H);
            if (i == 7) chk("R5 hreq released after first edge", hreq_o, 1'b1);
            sck_i = 1'b0;
        end
        cyc(H);
    endtask

    // Per-cycle comparison of the drive enables against the mode model
    always @(posedge clk) if (rst_n) settle <= settle + 1; else settle <= 0;
    always @(negedge clk) begin
        #1;
        if (rst_n && settle >= 3 && !finished) begin
            chk("R12 sck_oe", sck_oe, mode_master);
            chk("R12 mosi_oe", mosi_oe, mode_master);
            chk("R6 hreq_oe", hreq_oe, hreq_en & ~mode_master);
        end
    end

    initial begin
        logic [7:0] got;
        cyc(3);
        chk("R1 hreq_o", hreq_o, 1'b1);
        chk("R1 miso_oe", miso_oe, 1'b0);
        chk("R1 sck_o", sck_o, 1'b0);
        chk("R1 flags", {rx_valid, tx_full, bus_err, overrun}, 4'b0000);
        rst_n = 1'b1;
        cyc(6);

        // R2: unselected slave ignores SCK
        for (int i = 0; i < 8; i++) begin
            sck_i = 1'b1; cyc(H); sck_i = 1'b0; cyc(H);
        end
        chk("R2 rx_valid", rx_valid, 1'b0);
        chk("R2 miso_oe", miso_oe, 1'b0);
        chk("R5 hreq ready", hreq_o, 1'b0);

        // R3 / R4 / R5: selected slave word
        load_tx(8'hA5);
        chk("R4 tx_full set", tx_full, 1'b1);
        ss_n_i = 1'b0; cyc(4);
        chk("R4 miso_oe", miso_oe, 1'b1);
        chk("R5 hreq before word", hreq_o, 1'b0);
        exp_rx.push_back(8'h3C);
        slave_word(8'h3C, got);
        chk("R3 rx_valid", rx_valid, 1'b1);
        chk("R3 rx_data", rx_data, exp_rx.pop_front());
        chk("R4 miso word", got, 8'hA5);
        chk("R4 tx_full cleared", tx_full, 1'b0);
        chk("R5 hreq re-asserted", hreq_o, 1'b0);
        read_rx();
        chk("R10 rx_read clears", rx_valid, 1'b0);

        // R10: overrun
        slave_word(8'hC3, got);
        slave_word(8'h5A, got);
        chk("R10 overrun set", overrun, 1'b1);
        chk("R10 rx_data newest", rx_data, 8'h5A);
        clr_flags = 2'b10; cyc(1); clr_flags = 2'b00; cyc(1);
        chk("R10 overrun cleared", overrun, 1'b0);
        read_rx();
        ss_n_i = 1'b1; cyc(6);
        chk("R2 miso_oe after deselect", miso_oe, 1'b0);

        // Master mode
        mode_master = 1'b1; cyc(6);
        chk("R12 miso_oe in master", miso_oe, 1'b0);
        sl_sh = 8'h6D;
        load_tx(8'h96);
        cyc(20);
        chk("R7 no start without request", rise_cnt, 0);
        chk("R12 sck idle", sck_o, 1'b0);
        hreq_i = 1'b0;
        cyc(70);
        chk("R7 pulse count", rise_cnt, 8);
        chk("R7 mosi word", mosi_cap, 8'h96);
        chk("R7 rx word", rx_data, 8'h6D);
        chk("R11 period div2", t_last - t_prev, 2 * 3 * 20);
        chk("R12 sck idle after", sck_o, 1'b0);
        read_rx();

        // R8: request held low does not restart
        sl_sh = 8'h84;
        load_tx(8'h21);
        cyc(60);
        chk("R8 held request no start", rise_cnt, 8);
        chk("R8 word pending", tx_full, 1'b1);
        hreq_i = 1'b1; cyc(4); hreq_i = 1'b0;
        cyc(70);
        chk("R8 second word pulses", rise_cnt, 16);
        chk("R8 second mosi", mosi_cap, 8'h21);
        chk("R8 second rx", rx_data, 8'h84);
        read_rx();

        // R6 / R11: handshake disabled, slower divider
        hreq_en = 1'b0; hreq_i = 1'b1; clk_div = 8'd5;
        sl_sh = 8'h11;
        load_tx(8'h7E);
        cyc(120);
        chk("R6 start without request", rise_cnt, 24);
        chk("R6 mosi word", mosi_cap, 8'h7E);
        chk("R6 rx word", rx_data, 8'h11);
        chk("R11 period div5", t_last - t_prev, 2 * 6 * 20);
        chk("R6 hreq_oe off", hreq_oe, 1'b0);
        read_rx();

        // R9: bus error
        ss_n_i = 1'b0; cyc(4);
        chk("R9 bus_err set", bus_err, 1'b1);
        ss_n_i = 1'b1; cyc(4);
        chk("R9 bus_err sticky", bus_err, 1'b1);
        clr_flags = 2'b01; cyc(1); clr_flags = 2'b00; cyc(2);
        chk("R9 bus_err cleared", bus_err, 1'b0);

        // R6: enable back in slave mode
        mode_master = 1'b0; cyc(4);
        chk("R6 hreq_oe off in slave", hreq_oe, 1'b0);
        hreq_en = 1'b1; cyc(2);
        chk("R6 hreq_oe on in slave", hreq_oe, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule